// File: doc/BRIEF.md
# Two-Plane NAND Page Program Sequencer

This block runs on the host side of an 8-bit NAND flash bus. It writes two pages at once, one page into each plane. A single `start` pulse launches the operation. At that moment the caller presents two row addresses, one shared column address and a byte count per page. The data bytes then arrive over a valid/ready stream, first the bytes for the plane-0 page and then the bytes for the plane-1 page.

The sequencer first checks the plane-select row bit of each address. If either bit is wrong, it flags an error and never touches the bus.

Otherwise it loads the first page and closes that load with the dummy confirm command. It then waits out the short busy period on R/B#. Next it loads the second page and issues the real program confirm. After R/B# returns, it polls the status register until the ready bit is set, then reports pass or fail. Every busy wait has a programmable cycle limit. When the limit is reached, the operation is abandoned with a timeout flag.

The state machine has these states:
- `S_IDLE`: the bus is parked.
- `S_CMD_LOAD`: sends the load command.
- `S_ADDR`: sends the five address bytes.
- `S_FETCH`: takes one byte from the stream.
- `S_DATA`: writes that byte to the flash.
- `S_CMD_CONF`: sends the dummy confirm or the final confirm.
- `S_WAIT_DUMMY`: waits out the busy period after the dummy confirm.
- `S_WAIT_PROG`: waits out the program busy period.
- `S_CMD_STAT`: sends the status command.
- `S_READ_STAT`: strobes a status read.

The transitions are as follows:
- `S_IDLE`→`S_CMD_LOAD` on a valid start.
- `S_CMD_LOAD`→`S_ADDR` after the command beat.
- `S_ADDR`→`S_FETCH` after the fifth address byte. The target is `S_CMD_CONF` instead when the page length is zero.
- `S_FETCH`→`S_DATA` when a byte is accepted.
- `S_DATA`→`S_FETCH` while bytes remain.
- `S_DATA`→`S_CMD_CONF` after the last byte.
- `S_CMD_CONF`→`S_WAIT_DUMMY` in the plane-0 phase, or →`S_WAIT_PROG` in the plane-1 phase.
- `S_WAIT_DUMMY`→`S_CMD_LOAD` when R/B# is high. The machine then enters the plane-1 phase.
- `S_WAIT_PROG`→`S_CMD_STAT` when R/B# is high.
- `S_CMD_STAT`→`S_READ_STAT` after the command beat.
- `S_READ_STAT`→`S_READ_STAT` while the ready bit is clear. It leaves for `S_IDLE` when the ready bit is set.
- Any wait state or `S_READ_STAT`→`S_IDLE` on a timeout.

Top module: `mplane_prog_seq`

## Requirements
- R1: During reset and immediately after it:
  - `nand_ce_n`, `nand_we_n` and `nand_re_n` are 1.
  - `nand_cle`, `nand_ale`, `din_ready`, `done` and `busy` are 0.
- R2: The plane-select bit is bit 6 of each row address. If `row0_addr[6]` is not 0 or `row1_addr[6]` is not 1 at start, then:
  - `err_plane` and `done` go to 1 and `pass` is 0;
  - no WE# pulse is issued;
  - `nand_ce_n` stays 1.
- R3: In the plane-0 phase the bytes written are, in order:
  - command 80h;
  - `col_addr[7:0]`, `col_addr[15:8]`, then `row0_addr[7:0]`, `row0_addr[15:8]`, `row0_addr[23:16]`;
  - exactly `page_len` data bytes, in stream order;
  - command 11h.
- R4: Every written byte is captured on the rising edge of WE#, with these strobe levels:
  - command bytes have CLE=1 and ALE=0;
  - address bytes have CLE=0 and ALE=1;
  - data bytes have CLE=0 and ALE=0.
- R5: For every byte, WE# is low for exactly one clock. The I/O byte, CLE and ALE hold the same value through the WE# rising edge. CE# is low while WE# is low.
- R6: After command 11h or 10h, no WE# pulse occurs until R/B# has returned high.
- R7: In the plane-1 phase the bytes written are, in order:
  - command 81h;
  - the same two column bytes;
  - `row1_addr[7:0]`, `row1_addr[15:8]`, `row1_addr[23:16]`;
  - the next `page_len` data bytes;
  - command 10h.
- R8: After the program busy period, the block writes command 70h. It then pulses RE# low for one clock per read. It repeats the read while status bit 6 is 0.
- R9: When status bit 6 is 1, `done` becomes 1 and `pass` becomes the inverse of status bit 0. `done` and `pass` then hold until the next start.
- R10: If a busy wait or the status polling lasts `busy_limit` cycles without finishing, then:
  - `err_timeout` and `done` go to 1 and `pass` is 0;
  - the block returns to idle with `nand_ce_n`=1.
- R11: `din_ready` is asserted only while the block is waiting for a data byte. Exactly 2×`page_len` bytes are consumed per operation.
- R12: A start clears `done`, `err_plane` and `err_timeout` from the previous operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled in idle) |
| row0_addr | input | ROW_W | Row address of the plane-0 page |
| row1_addr | input | ROW_W | Row address of the plane-1 page |
| col_addr | input | COL_W | Column address shared by both pages |
| page_len | input | LEN_W | Data bytes per page |
| busy_limit | input | TO_W | Cycle limit for each busy wait |
| din | input | 8 | Data byte from the stream |
| din_valid | input | 1 | Stream byte valid |
| din_ready | output | 1 | Block accepts a stream byte |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_io_out | output | 8 | Byte driven onto the I/O bus |
| nand_io_oe | output | 1 | I/O output enable |
| nand_io_in | input | 8 | Byte read from the I/O bus |
| nand_rb_n | input | 1 | Ready/busy from the flash, low when busy |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished (held until next start) |
| pass | output | 1 | Program succeeded (valid with done) |
| err_plane | output | 1 | Plane-select bit check failed |
| err_timeout | output | 1 | A busy wait exceeded the limit |

## Verification
The bench builds the block with its default parameters:
- a 16-bit column address;
- a 24-bit row address, with the plane-select bit at row bit 6;
- a 13-bit length, which reaches the 4224-byte page size;
- a 16-bit timeout counter.

Because page length and timeout limit are run-time inputs, short pages of one and three bytes and a 20-cycle limit keep whole operations short, while still reaching the following cases:
- a zero-length page;
- a dummy busy period that never ends;
- repeated not-ready status reads;
- a failing status bit.

// File: rtl/mpp_pkg.sv
package mpp_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD_LOAD,
        S_ADDR,
        S_FETCH,
        S_DATA,
        S_CMD_CONF,
        S_WAIT_DUMMY,
        S_WAIT_PROG,
        S_CMD_STAT,
        S_READ_STAT
    } mpp_state_e;

    localparam logic [7:0] OP_LOAD_P0  = 8'h80;
    localparam logic [7:0] OP_LOAD_P1  = 8'h81;
    localparam logic [7:0] OP_CONF_DUM = 8'h11;
    localparam logic [7:0] OP_CONF_PRG = 8'h10;
    localparam logic [7:0] OP_STATUS   = 8'h70;

    localparam int STAT_RDY_BIT  = 6;
    localparam int STAT_FAIL_BIT = 0;

endpackage

// File: rtl/mpp_addr_sel.sv
module mpp_addr_sel #(
    parameter int COL_W = 16,
    parameter int ROW_W = 24,
    localparam int NBYTES = (COL_W + ROW_W) / 8,
    localparam int IDX_W  = $clog2(NBYTES)
) (
    input  logic [COL_W-1:0] col,
    input  logic [ROW_W-1:0] row,
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       byte_o
);
    logic [COL_W+ROW_W-1:0] packed_addr;
    logic [7:0]             slot [NBYTES];

    assign packed_addr = {row, col};

    for (genvar g = 0; g < NBYTES; g++) begin : g_slot
        assign slot[g] = packed_addr[g*8 +: 8];
    end

    always_comb begin
        byte_o = 8'h00;
        for (int k = 0; k < NBYTES; k++) begin
            if (idx == IDX_W'(k)) byte_o = slot[k];
        end
    end
endmodule

// File: rtl/mpp_busy_timer.sv
module mpp_busy_timer #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [TO_W-1:0] limit,
    output logic            expired
);
    logic [TO_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (cnt != '1) cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt >= limit);
endmodule

// File: rtl/mplane_prog_seq.sv
module mplane_prog_seq
    import mpp_pkg::*;
#(
    parameter int COL_W     = 16,
    parameter int ROW_W     = 24,
    parameter int LEN_W     = 13,
    parameter int TO_W      = 16,
    parameter int PLANE_BIT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [ROW_W-1:0] row0_addr,
    input  logic [ROW_W-1:0] row1_addr,
    input  logic [COL_W-1:0] col_addr,
    input  logic [LEN_W-1:0] page_len,
    input  logic [TO_W-1:0]  busy_limit,
    input  logic [7:0]       din,
    input  logic             din_valid,
    output logic             din_ready,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic             nand_ce_n,
    output logic [7:0]       nand_io_out,
    output logic             nand_io_oe,
    input  logic [7:0]       nand_io_in,
    input  logic             nand_rb_n,
    output logic             busy,
    output logic             done,
    output logic             pass,
    output logic             err_plane,
    output logic             err_timeout
);
    localparam int NADDR = (COL_W + ROW_W) / 8;
    localparam int IDX_W = $clog2(NADDR);

    mpp_state_e       state;
    logic             ph;
    logic             plane;
    logic [IDX_W-1:0] aidx;
    logic [LEN_W-1:0] bcnt;
    logic [LEN_W-1:0] len_q;
    logic [ROW_W-1:0] row0_q, row1_q;
    logic [COL_W-1:0] col_q;
    logic [7:0]       dq, stat_q;
    logic             done_q, pass_q, eplane_q, etime_q;
    logic [7:0]       addr_byte;
    logic             tmr_run, tmr_exp;

    mpp_addr_sel #(.COL_W(COL_W), .ROW_W(ROW_W)) u_addr (
        .col    (col_q),
        .row    (plane ? row1_q : row0_q),
        .idx    (aidx),
        .byte_o (addr_byte)
    );

    assign tmr_run = (state == S_WAIT_DUMMY) || (state == S_WAIT_PROG) ||
                     (state == S_READ_STAT);

    mpp_busy_timer #(.TO_W(TO_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmr_run),
        .limit   (busy_limit),
        .expired (tmr_exp)
    );

    // State register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            ph       <= 1'b0;
            plane    <= 1'b0;
            aidx     <= '0;
            bcnt     <= '0;
            len_q    <= '0;
            row0_q   <= '0;
            row1_q   <= '0;
            col_q    <= '0;
            dq       <= '0;
            stat_q   <= '0;
            done_q   <= 1'b0;
            pass_q   <= 1'b0;
            eplane_q <= 1'b0;
            etime_q  <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    ph <= 1'b0;
                    if (start) begin
                        done_q   <= 1'b0;
                        pass_q   <= 1'b0;
                        etime_q  <= 1'b0;
                        eplane_q <= 1'b0;
                        if (row0_addr[PLANE_BIT] || !row1_addr[PLANE_BIT]) begin
                            eplane_q <= 1'b1;
                            done_q   <= 1'b1;
                        end else begin
                            row0_q <= row0_addr;
                            row1_q <= row1_addr;
                            col_q  <= col_addr;
                            len_q  <= page_len;
                            plane  <= 1'b0;
                            state  <= S_CMD_LOAD;
                        end
                    end
                end
                S_CMD_LOAD: begin
                    ph <= ~ph;
                    if (ph) begin
                        aidx  <= '0;
                        state <= S_ADDR;
                    end
                end
                S_ADDR: begin
                    ph <= ~ph;
                    if (ph) begin
                        if (aidx == IDX_W'(NADDR - 1)) begin
                            bcnt  <= '0;
                            state <= (len_q == '0) ? S_CMD_CONF : S_FETCH;
                        end else begin
                            aidx <= aidx + 1'b1;
                        end
                    end
                end
                S_FETCH: begin
                    ph <= 1'b0;
                    if (din_valid) begin
                        dq    <= din;
                        state <= S_DATA;
                    end
                end
                S_DATA: begin
                    ph <= ~ph;
                    if (ph) begin
                        bcnt  <= bcnt + 1'b1;
                        state <= (bcnt + 1'b1 == len_q) ? S_CMD_CONF : S_FETCH;
                    end
                end
                S_CMD_CONF: begin
                    ph <= ~ph;
                    if (ph) state <= plane ? S_WAIT_PROG : S_WAIT_DUMMY;
                end
                S_WAIT_DUMMY: begin
                    ph <= 1'b0;
                    if (tmr_exp) begin
                        etime_q <= 1'b1;
                        done_q  <= 1'b1;
                        state   <= S_IDLE;
                    end else if (nand_rb_n) begin
                        plane <= 1'b1;
                        state <= S_CMD_LOAD;
                    end
                end
                S_WAIT_PROG: begin
                    ph <= 1'b0;
                    if (tmr_exp) begin
                        etime_q <= 1'b1;
                        done_q  <= 1'b1;
                        state   <= S_IDLE;
                    end else if (nand_rb_n) begin
                        state <= S_CMD_STAT;
                    end
                end
                S_CMD_STAT: begin
                    ph <= ~ph;
                    if (ph) state <= S_READ_STAT;
                end
                S_READ_STAT: begin
                    ph <= ~ph;
                    if (!ph) begin
                        stat_q <= nand_io_in;
                    end else if (stat_q[STAT_RDY_BIT]) begin
                        done_q <= 1'b1;
                        pass_q <= ~stat_q[STAT_FAIL_BIT];
                        state  <= S_IDLE;
                    end else if (tmr_exp) begin
                        etime_q <= 1'b1;
                        done_q  <= 1'b1;
                        state   <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Bus outputs
    always_comb begin
        nand_ce_n   = (state == S_IDLE);
        nand_we_n   = 1'b1;
        nand_re_n   = 1'b1;
        nand_cle    = 1'b0;
        nand_ale    = 1'b0;
        nand_io_out = 8'h00;
        nand_io_oe  = 1'b0;
        din_ready   = 1'b0;
        unique case (state)
            S_CMD_LOAD: begin
                nand_cle    = 1'b1;
                nand_io_out = plane ? OP_LOAD_P1 : OP_LOAD_P0;
                nand_we_n   = ph;
                nand_io_oe  = 1'b1;
            end
            S_ADDR: begin
                nand_ale    = 1'b1;
                nand_io_out = addr_byte;
                nand_we_n   = ph;
                nand_io_oe  = 1'b1;
            end
            S_FETCH: din_ready = 1'b1;
            S_DATA: begin
                nand_io_out = dq;
                nand_we_n   = ph;
                nand_io_oe  = 1'b1;
            end
            S_CMD_CONF: begin
                nand_cle    = 1'b1;
                nand_io_out = plane ? OP_CONF_PRG : OP_CONF_DUM;
                nand_we_n   = ph;
                nand_io_oe  = 1'b1;
            end
            S_CMD_STAT: begin
                nand_cle    = 1'b1;
                nand_io_out = OP_STATUS;
                nand_we_n   = ph;
                nand_io_oe  = 1'b1;
            end
            S_READ_STAT: nand_re_n = ph;
            default: ;
        endcase
    end

    assign busy        = (state != S_IDLE);
    assign done        = done_q;
    assign pass        = pass_q;
    assign err_plane   = eplane_q;
    assign err_timeout = etime_q;

endmodule

// File: rtl/mpp_prog_chk.sv
module mpp_prog_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       nand_rb_n,
    input logic       nand_cle,
    input logic       nand_ale,
    input logic       nand_we_n,
    input logic       nand_re_n,
    input logic       nand_ce_n,
    input logic [7:0] nand_io_out,
    input logic       done,
    input logic       pass,
    input logic       err_plane,
    input logic       err_timeout
);
    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale)); // R4

    AST_WE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nand_we_n) |-> ($stable(nand_io_out) && $stable(nand_cle) && $stable(nand_ale))); // R5

    AST_WE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |=> nand_we_n); // R5

    AST_WE_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> !nand_ce_n); // R5

    AST_NO_WE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_rb_n |-> nand_we_n); // R6

    AST_RE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |=> nand_re_n); // R8

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(pass))); // R9

    AST_PLANE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err_plane |-> (nand_ce_n && nand_we_n)); // R2

    AST_TIMEOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |-> (nand_ce_n && !pass)); // R10
endmodule

bind mplane_prog_seq mpp_prog_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .nand_rb_n   (nand_rb_n),
    .nand_cle    (nand_cle),
    .nand_ale    (nand_ale),
    .nand_we_n   (nand_we_n),
    .nand_re_n   (nand_re_n),
    .nand_ce_n   (nand_ce_n),
    .nand_io_out (nand_io_out),
    .done        (done),
    .pass        (pass),
    .err_plane   (err_plane),
    .err_timeout (err_timeout)
);

// File: tb/sim_mplane_prog_seq.sv
module sim_mplane_prog_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] row0_addr = '0, row1_addr = '0;
    logic [15:0] col_addr = '0;
    logic [12:0] page_len = '0;
    logic [15:0] busy_limit = 16'd1000;
    logic [7:0]  din;
    logic        din_valid = 1'b1;
    logic        din_ready;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_ce_n, nand_io_oe;
    logic [7:0]  nand_io_out, nand_io_in;
    logic        nand_rb_n = 1'b1;
    logic        busy, done, pass, err_plane, err_timeout;

    int errors = 0;
    int checks = 0;

    // flash model controls
    int  dbsy_cyc = 3, prog_cyc = 6, notready_reads = 0, reads = 0, busy_cnt = 0;
    bit  hold_busy = 0, fail_bit = 0;
    int  beats = 0;
    int  feed_idx = 0;
    bit  take_pend = 0;

    logic [9:0] expq[$];   // {cle, ale, byte}

    always #10 clk = ~clk;  // 50 MHz

    mplane_prog_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .row0_addr(row0_addr), .row1_addr(row1_addr), .col_addr(col_addr),
        .page_len(page_len), .busy_limit(busy_limit),
        .din(din), .din_valid(din_valid), .din_ready(din_ready),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_ce_n(nand_ce_n), .nand_io_out(nand_io_out),
        .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in), .nand_rb_n(nand_rb_n),
        .busy(busy), .done(done), .pass(pass), .err_plane(err_plane),
        .err_timeout(err_timeout)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    assign din = pat(feed_idx);
    assign nand_io_in = (reads < notready_reads) ? 8'h00 : {1'b0, 1'b1, 5'b0, fail_bit};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // stream source
    always @(negedge clk) begin
        if (take_pend) feed_idx++;
        take_pend = din_ready && din_valid;
    end

    // monitor / flash model
    logic       prev_we = 1'b1, prev_re = 1'b1;
    logic [9:0] prev_bus = '0;
    always @(negedge clk) begin
        logic [9:0] bus, e;
        bus = {nand_cle, nand_ale, nand_io_out};
        if (!prev_we && nand_we_n) begin
            beats++;
            chk(bus == prev_bus, "R5 bus stable at WE rise", int'(bus), int'(prev_bus));
            chk(nand_rb_n == 1'b1, "R6 write while busy", int'(nand_rb_n), 1);
            if (expq.size() == 0) begin
                chk(1'b0, "R3/R7 unexpected beat", int'(bus), 0);
            end else begin
                e = expq.pop_front();
                chk(bus == e, "R3/R7/R4 beat", int'(bus), int'(e));
            end
            if (nand_cle && (nand_io_out == 8'h11 || nand_io_out == 8'h10)) begin
                nand_rb_n = 1'b0;
                busy_cnt  = (nand_io_out == 8'h11) ? dbsy_cyc : prog_cyc;
            end
        end else if (!nand_rb_n && !hold_busy) begin
            if (busy_cnt == 0) nand_rb_n = 1'b1;
            else busy_cnt--;
        end
        if (!prev_re && nand_re_n) reads++;
        prev_we  = nand_we_n;
        prev_re  = nand_re_n;
        prev_bus = bus;
    end

    task automatic push(input logic c, input logic a, input logic [7:0] b);
        expq.push_back({c, a, b});
    endtask

    task automatic run_op(input logic [23:0] r0, input logic [23:0] r1,
                          input logic [15:0] c, input int len);
        int base;
        base = feed_idx;
        expq.delete();
        reads = 0;
        if (!r0[6] && r1[6]) begin
            push(1, 0, 8'h80);
            push(0, 1, c[7:0]); push(0, 1, c[15:8]);
            push(0, 1, r0[7:0]); push(0, 1, r0[15:8]); push(0, 1, r0[23:16]);
            for (int i = 0; i < len; i++) push(0, 0, pat(base + i));
            push(1, 0, 8'h11);
            push(1, 0, 8'h81);
            push(0, 1, c[7:0]); push(0, 1, c[15:8]);
            push(0, 1, r1[7:0]); push(0, 1, r1[15:8]); push(0, 1, r1[23:16]);
            for (int i = 0; i < len; i++) push(0, 0, pat(base + len + i));
            push(1, 0, 8'h10);
            push(1, 0, 8'h70);
        end
        row0_addr = r0; row1_addr = r1; col_addr = c; page_len = 13'(len);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", wd);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int b0, f0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(nand_ce_n && nand_we_n && nand_re_n, "R1 strobes idle", {nand_ce_n, nand_we_n, nand_re_n}, 7);
        chk(!nand_cle && !nand_ale && !din_ready, "R1 latches low", {nand_cle, nand_ale, din_ready}, 0);
        chk(!done && !busy, "R1 done/busy", {done, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(nand_ce_n && !done && !busy, "R1 after reset", {nand_ce_n, done, busy}, 4);

        // normal pass with status polling
        notready_reads = 2; fail_bit = 0;
        f0 = feed_idx;
        run_op(24'h12_34_05, 24'h12_34_45, 16'h0A5C, 3);
        chk(expq.size() == 0, "R3/R7/R8 all beats seen", expq.size(), 0);
        chk(done && pass && !err_plane && !err_timeout, "R9 pass result",
            {done, pass, err_plane, err_timeout}, 12);
        chk(reads == 3, "R8 status reads", reads, 3);
        chk(feed_idx - f0 == 6, "R11 bytes consumed", feed_idx - f0, 6);
        repeat (10) @(negedge clk);
        chk(done && pass && !din_ready, "R9 result held", {done, pass, din_ready}, 6);

        // fail bit
        notready_reads = 0; fail_bit = 1;
        f0 = feed_idx;
        run_op(24'hFF_00_3F, 24'h00_00_40, 16'h1000, 1);
        chk(expq.size() == 0, "R3/R7 beats len1", expq.size(), 0);
        chk(done && !pass, "R9 fail result", {done, pass}, 2);
        chk(feed_idx - f0 == 2, "R11 bytes len1", feed_idx - f0, 2);

        // zero-length pages
        fail_bit = 0;
        run_op(24'h00_00_00, 24'h00_00_40, 16'h0000, 0);
        chk(expq.size() == 0 && pass, "R3/R7 zero length", expq.size(), 0);

        // plane errors
        b0 = beats;
        run_op(24'h00_00_40, 24'h00_00_40, 16'h0001, 2);
        chk(err_plane && done && !pass, "R2 plane0 bit set", {err_plane, done, pass}, 6);
        chk(beats == b0 && nand_ce_n, "R2 no bus activity", beats - b0, 0);
        run_op(24'h00_00_00, 24'h00_00_00, 16'h0001, 2);
        chk(err_plane && beats == b0, "R2 plane1 bit clear", err_plane, 1);

        // R12 flags cleared by a good start
        run_op(24'h00_01_00, 24'h00_01_40, 16'h0002, 1);
        chk(!err_plane && pass, "R12 error cleared", err_plane, 0);

        // timeout on dummy busy
        hold_busy = 1; busy_limit = 16'd20;
        run_op(24'h00_02_00, 24'h00_02_40, 16'h0003, 1);
        chk(err_timeout && done && !pass && nand_ce_n, "R10 timeout",
            {err_timeout, done, pass, nand_ce_n}, 13);
        hold_busy = 0; busy_cnt = 0;
        repeat (3) @(negedge clk);
        busy_limit = 16'd1000;
        run_op(24'h00_03_00, 24'h00_03_40, 16'h0004, 2);
        chk(!err_timeout && pass, "R12 timeout cleared", err_timeout, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule